// File: doc/BRIEF.md
# Transposed Four-Tap FIR Filter

This block is a four-tap finite impulse response filter. It accepts one unsigned 32-bit sample per clock when the input valid flag is high, and returns one filtered result on the clock after each accepted sample. The four weights are fixed unsigned 5-bit constants held in a small read-only table inside the block. The weights cannot be changed at run time.

The filter uses the transposed form. Every accepted sample is broadcast to all taps at once. Each tap is one processing element: a multiplier followed by an adder. Each tap adds its product to the registered partial sum coming from the tap after it, and registers the result. No register-to-register path therefore crosses more than one multiply-add, however many taps there are. The partial-sum registers act as the delay line. They advance only on accepted samples, so idle cycles leave the filter history untouched. A synchronous reset clears every partial sum.

The result width is the sample width plus the weight width plus two guard bits (39 bits). The sum of four full-scale products always fits.

Top module: `fir4t_transposed`

## Requirements
- R1: While reset is high, each clock edge clears `out_valid` to 0 and `out_sample` to 0.
- R2: `out_valid` equals `in_valid` as sampled at the previous clock edge; it is never high in other cycles.
- R3: On each valid output, `out_sample` = 2·x(n) + 31·x(n−1) + 17·x(n−2) + 9·x(n−3). Here x(n) is the most recently accepted sample and x(n−k) is the sample accepted k samples earlier; samples earlier than the last reset count as zero. The weights are h0=2, h1=31, h2=17, h3=9, applied in that order.
- R4: A single sample of value 1 followed by zero samples yields the outputs 2, 31, 17, 9 and then 0, on consecutive accepted samples.
- R5: The result never overflows. A run of all-ones samples produces exactly 59·(2^32−1) once four of them have been accepted.
- R6: A cycle with `in_valid` low has no effect on the filter history, and `out_sample` keeps its previous value. The next valid output equals the value it would have had with no idle cycles in between.
- R7: A reset applied mid-stream discards all earlier samples. The first output after reset equals 2·x for the new sample x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_sample` carries a sample to accept |
| in_sample | input | 32 | Unsigned input sample |
| out_valid | output | 1 | High for one cycle per accepted sample, one clock after it |
| out_sample | output | 39 | Unsigned filtered result; holds its value between valid outputs |

## Verification
The impulse test feeds a single unit sample. It exposes swapped or reversed weights, which would show up as 9, 17, 31, 2 or as a reordered sequence. It also exposes a broken partial-sum link, which would drop or repeat a term.

Long runs of all-ones samples catch a truncated accumulator. Such a design would wrap and return a value far below 59·(2^32−1).

Idle gaps in the middle of a stream catch a delay line that shifts on every clock instead of on accepted samples. That design would fold zeros into the next result and change `out_sample` during the gap.

A reset between two streams catches partial sums that survive reset. These would leak old samples into the first new output.

// File: rtl/fir4t_pkg.sv
`timescale 1ns/1ps
package fir4t_pkg;
  localparam int COEF_W  = 5;
  localparam int NUM_TAP = 4;

  // Fixed weight table, indexed from the newest sample (0) to the oldest.
  function automatic logic [COEF_W-1:0] coef_at(input int idx);
    case (idx)
      0:       coef_at = 5'd2;
      1:       coef_at = 5'd31;
      2:       coef_at = 5'd17;
      3:       coef_at = 5'd9;
      default: coef_at = '0;
    endcase
  endfunction

  function automatic int coef_total(input int taps);
    int acc;
    acc = 0;
    for (int k = 0; k < taps; k++) acc += int'(coef_at(k));
    return acc;
  endfunction
endpackage

// File: rtl/fir4t_coef_rom.sv
`timescale 1ns/1ps
module fir4t_coef_rom
  import fir4t_pkg::*;
#(
  parameter int NTAPS = NUM_TAP
) (
  output logic [COEF_W-1:0] coef [NTAPS]
);
  for (genvar g = 0; g < NTAPS; g++) begin : g_entry
    assign coef[g] = coef_at(g);
  end
endmodule

// File: rtl/fir4t_pe.sv
`timescale 1ns/1ps
module fir4t_pe
  import fir4t_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 39
) (
  input  logic [COEF_W-1:0] coef,
  input  logic [IN_W-1:0]   sample,
  input  logic [OUT_W-1:0]  carry_in,
  output logic [OUT_W-1:0]  sum
);
  // One multiply feeding one add: the only logic between two stage registers.
  function automatic logic [OUT_W-1:0] mac(
    input logic [COEF_W-1:0] w,
    input logic [IN_W-1:0]   x,
    input logic [OUT_W-1:0]  acc
  );
    logic [OUT_W-1:0] prod;
    prod = OUT_W'(w) * OUT_W'(x);
    return prod + acc;
  endfunction

  assign sum = mac(coef, sample, carry_in);
endmodule

// File: rtl/fir4t_stage_reg.sv
`timescale 1ns/1ps
module fir4t_stage_reg #(
  parameter int W = 39
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fir4t_transposed.sv
`timescale 1ns/1ps
module fir4t_transposed
  import fir4t_pkg::*;
#(
  parameter  int IN_W  = 32,
  parameter  int NTAPS = NUM_TAP,
  localparam int OUT_W = IN_W + COEF_W + $clog2(NTAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_sample
);
  // Named event: a sample is taken into the filter this cycle.
  logic sample_accept;
  assign sample_accept = in_valid;

  logic [COEF_W-1:0] coef     [NTAPS];
  logic [OUT_W-1:0]  carry_in [NTAPS];
  logic [OUT_W-1:0]  stage_d  [NTAPS];
  logic [OUT_W-1:0]  stage_q  [NTAPS];
  logic              valid_q;

  fir4t_coef_rom #(.NTAPS(NTAPS)) u_rom (.coef(coef));

  // Stage g holds the partial sum that still lacks the g newest products.
  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    if (g == NTAPS - 1) begin : g_tail
      assign carry_in[g] = '0;
    end else begin : g_link
      assign carry_in[g] = stage_q[g+1];
    end

    fir4t_pe #(.IN_W(IN_W), .OUT_W(OUT_W)) u_pe (
      .coef    (coef[g]),
      .sample  (in_sample),
      .carry_in(carry_in[g]),
      .sum     (stage_d[g])
    );

    fir4t_stage_reg #(.W(OUT_W)) u_reg (
      .clk(clk),
      .rst(rst),
      .en (sample_accept),
      .d  (stage_d[g]),
      .q  (stage_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= sample_accept;
  end

  assign out_valid  = valid_q;
  assign out_sample = stage_q[0];
endmodule

// File: rtl/fir4t_checker.sv
`timescale 1ns/1ps
module fir4t_checker
  import fir4t_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int NTAPS = NUM_TAP,
  parameter int OUT_W = 39
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_accept,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_sample
);
  localparam logic [OUT_W-1:0] FULL_IN = OUT_W'({IN_W{1'b1}});
  localparam logic [OUT_W-1:0] BOUND   = FULL_IN * OUT_W'(coef_total(NTAPS));

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      AST_RESET_CLEAR: assert (out_valid == 1'b0 && out_sample == '0)
        else $error("reset did not clear outputs"); // R1
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    sample_accept |=> out_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !sample_accept |=> !out_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_accept |=> $stable(out_sample)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    sample_accept |=> (out_sample <= BOUND)); // R5
endmodule

bind fir4t_transposed fir4t_checker #(
  .IN_W (IN_W),
  .NTAPS(NTAPS),
  .OUT_W(OUT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_accept(sample_accept),
  .out_valid    (out_valid),
  .out_sample   (out_sample)
);

// File: tb/fir4t_transposed_tb.sv
`timescale 1ns/1ps
module fir4t_transposed_tb;
  localparam int IN_W  = 32;
  localparam int OUT_W = 39;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [IN_W-1:0]  in_sample = '0;
  logic             out_valid;
  logic [OUT_W-1:0] out_sample;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  longint unsigned hist [4];
  longint unsigned last_out;
  logic [31:0]     seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  fir4t_transposed u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic longint unsigned weight(input int k);
    case (k)
      0: return 2;
      1: return 31;
      2: return 17;
      default: return 9;
    endcase
  endfunction

  task automatic check(input longint unsigned act, input longint unsigned exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < 4; k++) hist[k] = 0;
    last_out = 0;
  endtask

  // Drive one cycle, then check the outputs one edge later.
  task automatic step(input bit v, input logic [31:0] x, input string tag);
    in_valid  = v;
    in_sample = x;
    @(posedge clk);
    #1;
    if (v) begin
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(x);
      last_out = 0;
      for (int k = 0; k < 4; k++) last_out += weight(k) * hist[k];
    end
    check(longint'(out_valid), longint'(v), {tag, " valid"});
    check(longint'(out_sample), last_out, {tag, " data"});
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    check(longint'(out_valid), 0, {tag, " valid cleared"});
    check(longint'(out_sample), 0, {tag, " data cleared"});
    rst = 1'b0;
    clear_model();
  endtask

  task automatic t_reset();
    do_reset("R1 reset");
  endtask

  task automatic t_impulse();
    step(1'b1, 32'd1, "R4 impulse h0");
    check(longint'(out_sample), 2, "R4 impulse first=2");
    step(1'b1, 32'd0, "R4 impulse h1");
    check(longint'(out_sample), 31, "R4 impulse second=31");
    step(1'b1, 32'd0, "R4 impulse h2");
    check(longint'(out_sample), 17, "R4 impulse third=17");
    step(1'b1, 32'd0, "R4 impulse h3");
    check(longint'(out_sample), 9, "R4 impulse fourth=9");
    step(1'b1, 32'd0, "R4 impulse tail");
    check(longint'(out_sample), 0, "R4 impulse tail=0");
  endtask

  task automatic t_valid_pattern();
    for (int i = 0; i < 12; i++) step(bit'(i % 3 != 1), 32'(i * 7 + 3), "R2 valid pattern");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 40; i++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      step(1'b1, seed, "R3 stream");
    end
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < 6; i++) step(1'b1, 32'hFFFF_FFFF, "R5 full scale");
    check(longint'(out_sample), 59 * 64'h0000_0000_FFFF_FFFF, "R5 no overflow exact");
  endtask

  task automatic t_idle_gap();
    step(1'b1, 32'd100, "R6 pre-gap a");
    step(1'b1, 32'd7, "R6 pre-gap b");
    for (int i = 0; i < 3; i++) step(1'b0, 32'hDEAD_BEEF, "R6 idle hold");
    step(1'b1, 32'd5, "R6 post-gap");
    step(1'b1, 32'd0, "R6 post-gap 2");
  endtask

  task automatic t_mid_reset();
    step(1'b1, 32'd999, "R7 pre-reset a");
    step(1'b1, 32'd4321, "R7 pre-reset b");
    do_reset("R7 mid reset");
    step(1'b1, 32'd50, "R7 first after reset");
    check(longint'(out_sample), 100, "R7 first after reset = 2x");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    clear_model();
    t_reset();
    t_impulse();
    t_valid_pattern();
    t_stream();
    t_full_scale();
    t_idle_gap();
    t_mid_reset();
    t_stream();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule